// File: doc/BRIEF.md
# Nine-Bit Serial Register Port

This block is the control port through which a host processor programs a display bridge. The host sends 9-bit serial words in SPI mode 0. The first bit of each word marks it as an address (command) word or a data word. Data words fill 16-bit registers one byte at a time, low byte first. A dedicated address makes the data words that follow it go into a byte buffer instead of a register, up to a programmed length. The host reads a register back with a short arming sequence, after which the port shifts the selected value out on MISO.

The serial pins are brought into the system clock domain through a two-flop synchronizer, and the SCLK rising edge is detected there. The system clock must run at least four times faster than SCLK. The register file spans addresses 0xB0 to 0xEB. Address 0xB0 is a fixed identifier. A write of 0x0100 to address 0xC0 returns every register to its default value. The configuration register at 0xB7 is also driven to the rest of the chip in parallel, together with its packet-type flag.

Top module: `ctl9_port`

## Requirements
- R1: Each serial word is 9 bits, sampled on SCLK rising edges while chip select is low. The first bit is 0 for a command word and 1 for a data word. The next 8 bits are the value, most significant bit first.
- R2: A register write is a command word carrying the address, then a data word with bits 7:0, then a data word with bits 15:8. The register takes the new value when the second data word completes.
- R3: Chip select going high discards any partly shifted word and cancels a write whose high byte has not yet arrived. The register keeps its previous value.
- R4: A command word of 0xBF clears the payload count. Each following data word is stored at payload index count, and count then increments. This continues only while count is below both the value of register 0xBC and the buffer depth. Further bytes are ignored.
- R5: A readback is a write of 0x00FA to register 0xD4, then a command word with the target address, then a command word 0xFA. The next 16 SCLK cycles present the target's value on MISO, most significant bit first, with each bit valid before its SCLK rising edge. MISO is low at all other times.
- R6: Address 0xB0 reads back the DEV_ID parameter. Writes to it are ignored.
- R7: Writes to addresses outside 0xB0 to 0xEB are ignored, and reads from those addresses return zero.
- R8: Writing exactly 0x0100 to address 0xC0 sets every register to its default and clears the payload count. The defaults are zero for all registers except 0xB7, which takes CFG_DEF. Any other value written to 0xC0 is simply stored.
- R9: cfg_word always equals register 0xB7, and dcs_sel equals its bit 6.
- R10: During the 16 readback cycles, MOSI is not assembled into words. Word framing resumes with the first SCLK cycle after the readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Readback data to host |
| cfg_word | output | 16 | Current value of configuration register 0xB7 |
| dcs_sel | output | 1 | Packet-type flag, bit 6 of 0xB7 |
| pay_count | output | $clog2(PAY_DEPTH+1) | Number of payload bytes stored |
| pay_rd_idx | input | $clog2(PAY_DEPTH) | Payload buffer read index |
| pay_rd_byte | output | 8 | Payload byte at pay_rd_idx |

## Verification
Two functions meet in the same cycle when the high data byte of the arming write to 0xD4 completes. That word both commits the register write that arms the readback and is a data word, which would otherwise drop a pending readback. Arming must take priority.

Every readback in the bench goes through this collision. Its result is judged on MISO: a wrong priority either shifts out nothing or leaves the port waiting. A second overlap is the cycle in which the final readback bit ends the shift phase while word framing restarts. It is provoked by sending a full register write immediately after a readback without raising chip select, and judged by reading that register back.

// File: rtl/ctl9_pkg.sv
// Shared constants and types for the nine-bit serial register port.
// Assumes 8-bit register addresses and 16-bit register values.
package ctl9_pkg;
    localparam logic [7:0]  ADDR_ID    = 8'hB0;
    localparam logic [7:0]  ADDR_FIRST = 8'hB1;
    localparam logic [7:0]  ADDR_LAST  = 8'hEB;
    localparam logic [7:0]  ADDR_CFG   = 8'hB7;
    localparam logic [7:0]  ADDR_PLEN  = 8'hBC;
    localparam logic [7:0]  ADDR_PAY   = 8'hBF;
    localparam logic [7:0]  ADDR_OPS   = 8'hC0;
    localparam logic [7:0]  ADDR_RDSEL = 8'hD4;
    localparam logic [7:0]  RD_KEY     = 8'hFA;
    localparam logic [15:0] SRST_VAL   = 16'h0100;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_ARMED  = 2'd1,
        RD_TARGET = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic       is_data;
        logic [7:0] val;
    } word9_t;
endpackage

// File: rtl/ctl9_sync.sv
// Multi-stage synchronizer for a group of asynchronous pins.
// Assumes each bit is an independent level; STAGES >= 2.
module ctl9_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Purpose: one flop rank of the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg[g] <= RST_VAL;
            else if (g == 0)
                stg[g] <= d_in;
            else
                stg[g] <= stg[(g == 0) ? 0 : g-1];
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/ctl9_shift.sv
// Serial shifter: frames incoming 9-bit words on SCLK rising edges and
// shifts a 16-bit readback value out, MSB first, after a load pulse.
// Assumes synchronized inputs and a clock ratio of at least 4.
module ctl9_shift
    import ctl9_pkg::*;
#(
    parameter int WORD_BITS = 9,
    parameter int TX_BITS   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_s,
    input  logic               sclk_s,
    input  logic               mosi_s,
    input  logic               tx_load,
    input  logic [TX_BITS-1:0] tx_val,
    output logic               word_vld,
    output word9_t             word,
    output logic               tx_active,
    output logic               tx_msb
);
    localparam int BC_W = $clog2(WORD_BITS);
    localparam int TC_W = $clog2(TX_BITS);
    localparam logic [BC_W-1:0] BIT_LAST = BC_W'(WORD_BITS - 1);
    localparam logic [TC_W-1:0] TX_LAST  = TC_W'(TX_BITS - 1);

    logic                 sclk_d;
    logic                 sclk_rise;
    logic [BC_W-1:0]      bit_cnt;
    logic [WORD_BITS-2:0] rx_sh;
    logic [TX_BITS-1:0]   tx_sh;
    logic [TC_W-1:0]      tx_cnt;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign tx_msb    = tx_sh[TX_BITS-1];

    // Purpose: remember the previous SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Purpose: word framing and readback shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            word_vld  <= 1'b0;
            word      <= '0;
            tx_sh     <= '0;
            tx_cnt    <= '0;
            tx_active <= 1'b0;
        end else if (cs_s) begin
            bit_cnt   <= '0;
            word_vld  <= 1'b0;
            tx_active <= 1'b0;
            tx_cnt    <= '0;
        end else begin
            word_vld <= 1'b0;
            if (tx_load) begin
                tx_sh     <= tx_val;
                tx_cnt    <= '0;
                tx_active <= 1'b1;
                bit_cnt   <= '0;
            end else if (sclk_rise) begin
                if (tx_active) begin
                    tx_sh  <= {tx_sh[TX_BITS-2:0], 1'b0};
                    tx_cnt <= tx_cnt + 1'b1;
                    if (tx_cnt == TX_LAST)
                        tx_active <= 1'b0;
                end else begin
                    rx_sh <= {rx_sh[WORD_BITS-3:0], mosi_s};
                    if (bit_cnt == BIT_LAST) begin
                        bit_cnt  <= '0;
                        word_vld <= 1'b1;
                        word     <= {rx_sh, mosi_s};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ctl9_regfile.sv
// Register file for addresses 0xB0..0xEB: fixed identifier at 0xB0,
// storage elsewhere, soft reset on 0x0100 written to 0xC0.
// Assumes writes arrive as single-cycle pulses with full 16-bit data.
module ctl9_regfile
    import ctl9_pkg::*;
#(
    parameter logic [15:0] DEV_ID  = 16'h5A31,
    parameter logic [15:0] CFG_DEF = 16'h0300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        srst,
    output logic [15:0] cfg_q,
    output logic [15:0] plen_q
);
    localparam int NREG     = int'(ADDR_LAST) - int'(ADDR_FIRST) + 1;
    localparam int CFG_IDX  = int'(ADDR_CFG)  - int'(ADDR_FIRST);
    localparam int PLEN_IDX = int'(ADDR_PLEN) - int'(ADDR_FIRST);

    logic [15:0] regs [NREG];

    assign srst = wr_en && (wr_addr == ADDR_OPS) && (wr_data == SRST_VAL);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [7:0]  MY_ADDR = 8'(int'(ADDR_FIRST) + i);
        localparam logic [15:0] MY_DEF  = (MY_ADDR == ADDR_CFG) ? CFG_DEF : 16'h0000;
        // Purpose: hold one register; soft reset wins over the write.
        always_ff @(posedge clk) begin
            if (!rst_n || srst)
                regs[i] <= MY_DEF;
            else if (wr_en && wr_addr == MY_ADDR)
                regs[i] <= wr_data;
        end
    end

    // Purpose: readback mux; unimplemented addresses give zero.
    always_comb begin
        rd_data = 16'h0000;
        if (rd_addr == ADDR_ID)
            rd_data = DEV_ID;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == 8'(int'(ADDR_FIRST) + i))
                rd_data = regs[i];
    end

    assign cfg_q  = regs[CFG_IDX];
    assign plen_q = regs[PLEN_IDX];
endmodule

// File: rtl/ctl9_payload.sv
// Payload byte buffer with a running count, bounded by a programmed
// length and by its depth. Assumes push and clear are one-cycle pulses.
module ctl9_payload #(
    parameter int DEPTH = 16,
    parameter int LEN_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [7:0]                 din,
    input  logic [LEN_W-1:0]           len_lim,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [7:0]                 rd_byte,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [7:0] mem [DEPTH];
    logic       accept;

    assign accept  = push && (count != FULL) && (LEN_W'(count) < len_lim);
    assign rd_byte = mem[rd_idx];

    // Purpose: count stored bytes; clear restarts the packet.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (accept)   count <= count + 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_mem
        // Purpose: one payload byte slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= 8'h00;
            else if (accept && count[IDX_W-1:0] == IDX_W'(i))
                mem[i] <= din;
        end
    end
endmodule

// File: rtl/ctl9_port.sv
// Top of the nine-bit serial register port. Synchronizes the pins,
// frames words, decodes command/data, assembles writes, routes packet
// bytes and sequences readback. Assumes SPI mode 0 and clk >= 4x SCLK.
module ctl9_port
    import ctl9_pkg::*;
#(
    parameter int          PAY_DEPTH   = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] DEV_ID      = 16'h5A31,
    parameter logic [15:0] CFG_DEF     = 16'h0300
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           spi_sclk,
    input  logic                           spi_cs_n,
    input  logic                           spi_mosi,
    output logic                           spi_miso,
    output logic [15:0]                    cfg_word,
    output logic                           dcs_sel,
    output logic [$clog2(PAY_DEPTH+1)-1:0] pay_count,
    input  logic [$clog2(PAY_DEPTH)-1:0]   pay_rd_idx,
    output logic [7:0]                     pay_rd_byte
);
    logic [2:0] pin_s;
    logic       sclk_s, cs_s, mosi_s;

    ctl9_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({spi_sclk, spi_cs_n, spi_mosi}),
        .q_out (pin_s)
    );
    assign sclk_s = pin_s[2];
    assign cs_s   = pin_s[1];
    assign mosi_s = pin_s[0];

    word9_t      word;
    logic        word_vld, tx_active, tx_msb, tx_load;
    logic [15:0] tx_val;

    ctl9_shift #(.WORD_BITS(9), .TX_BITS(16)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .sclk_s    (sclk_s),
        .mosi_s    (mosi_s),
        .tx_load   (tx_load),
        .tx_val    (tx_val),
        .word_vld  (word_vld),
        .word      (word),
        .tx_active (tx_active),
        .tx_msb    (tx_msb)
    );

    logic [7:0]  cur_addr, lo_byte, rd_addr;
    logic        hi_phase;
    rd_state_e   rd_st;
    logic        is_cmd, is_dat, pay_sel, wr_en, pay_push, pay_clr, arm_hit, srst;
    logic [15:0] wr_data, plen_q;

    assign is_cmd   = word_vld & ~word.is_data;
    assign is_dat   = word_vld &  word.is_data;
    assign pay_sel  = (cur_addr == ADDR_PAY);
    assign wr_en    = is_dat & hi_phase & ~pay_sel;
    assign wr_data  = {word.val, lo_byte};
    assign pay_push = is_dat & pay_sel;
    assign pay_clr  = is_cmd & (word.val == ADDR_PAY);
    assign tx_load  = is_cmd & (rd_st == RD_TARGET) & (word.val == RD_KEY);
    assign arm_hit  = wr_en & (cur_addr == ADDR_RDSEL) & (wr_data == {8'h00, RD_KEY});

    // Purpose: command/data decode, write assembly and readback sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            cur_addr <= 8'h00;
            lo_byte  <= 8'h00;
            hi_phase <= 1'b0;
            rd_st    <= RD_IDLE;
            rd_addr  <= 8'h00;
        end else if (cs_s) begin
            hi_phase <= 1'b0;
        end else if (word_vld) begin
            if (!word.is_data) begin
                cur_addr <= word.val;
                hi_phase <= 1'b0;
                if (tx_load)
                    rd_st <= RD_IDLE;
                else if (rd_st != RD_IDLE) begin
                    rd_addr <= word.val;
                    rd_st   <= RD_TARGET;
                end
            end else begin
                if (!pay_sel) begin
                    if (!hi_phase) lo_byte <= word.val;
                    hi_phase <= ~hi_phase;
                end
                if (arm_hit)               rd_st <= RD_ARMED;
                else if (rd_st != RD_IDLE) rd_st <= RD_IDLE;
            end
        end
    end

    ctl9_regfile #(.DEV_ID(DEV_ID), .CFG_DEF(CFG_DEF)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (cur_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (tx_val),
        .srst    (srst),
        .cfg_q   (cfg_word),
        .plen_q  (plen_q)
    );

    ctl9_payload #(.DEPTH(PAY_DEPTH), .LEN_W(16)) u_pay (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pay_clr | srst),
        .push    (pay_push),
        .din     (word.val),
        .len_lim (plen_q),
        .rd_idx  (pay_rd_idx),
        .rd_byte (pay_rd_byte),
        .count   (pay_count)
    );

    assign spi_miso = tx_active & tx_msb;
    assign dcs_sel  = cfg_word[6];
endmodule

// File: rtl/ctl9_port_chk.sv
// Property checker for ctl9_port, attached by bind below.
module ctl9_port_chk #(
    parameter int          PAY_DEPTH = 16,
    parameter logic [15:0] CFG_DEF   = 16'h0300
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cs_s,
    input logic                           word_vld,
    input logic                           tx_active,
    input logic                           spi_miso,
    input logic                           srst,
    input logic [15:0]                    cfg_word,
    input logic [$clog2(PAY_DEPTH+1)-1:0] pay_count
);
    localparam int CNT_W = $clog2(PAY_DEPTH+1);

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !spi_miso);  // R5
    AST_NO_RX_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !word_vld);  // R10
    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!word_vld && !tx_active));  // R3
    AST_PAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pay_count) <= PAY_DEPTH);  // R4
    AST_PAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_count != $past(pay_count)) |->
            (pay_count == CNT_W'($past(pay_count) + 1'b1) || pay_count == '0));  // R4
    AST_SRST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (cfg_word == CFG_DEF && pay_count == '0));  // R8
endmodule

bind ctl9_port ctl9_port_chk #(.PAY_DEPTH(PAY_DEPTH), .CFG_DEF(CFG_DEF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .word_vld  (word_vld),
    .tx_active (tx_active),
    .spi_miso  (spi_miso),
    .srst      (srst),
    .cfg_word  (cfg_word),
    .pay_count (pay_count)
);

// File: tb/sim_ctl9_port.sv
module sim_ctl9_port;
    localparam logic [15:0] DEV_ID  = 16'h5A31;
    localparam logic [15:0] CFG_DEF = 16'h0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] cfg_word;
    logic        dcs_sel;
    logic [4:0]  pay_count;
    logic [3:0]  pay_rd_idx = 4'd0;
    logic [7:0]  pay_rd_byte;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    ctl9_port #(.PAY_DEPTH(16), .DEV_ID(DEV_ID), .CFG_DEF(CFG_DEF)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cfg_word(cfg_word),
        .dcs_sel(dcs_sel), .pay_count(pay_count), .pay_rd_idx(pay_rd_idx),
        .pay_rd_byte(pay_rd_byte)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic so);
        spi_mosi = b;
        tick(4);
        so = spi_miso;
        spi_sclk = 1'b1;
        tick(4);
        spi_sclk = 1'b0;
    endtask

    task automatic spi_word(input logic is_data, input logic [7:0] v);
        logic so;
        spi_bit(is_data, so);
        for (int i = 7; i >= 0; i--) spi_bit(v[i], so);
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0;
        tick(4);
    endtask

    task automatic cs_high();
        spi_cs_n = 1'b1;
        tick(6);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [15:0] v);
        cs_low();
        spi_word(1'b0, a);
        spi_word(1'b1, v[7:0]);
        spi_word(1'b1, v[15:8]);
        cs_high();
    endtask

    // Readback sequence; keep_cs leaves chip select low afterwards.
    task automatic rd_reg(input logic [7:0] a, input bit keep_cs, output logic [15:0] v);
        logic so;
        cs_low();
        spi_word(1'b0, 8'hD4);
        spi_word(1'b1, 8'hFA);
        spi_word(1'b1, 8'h00);
        spi_word(1'b0, a);
        spi_word(1'b0, 8'hFA);
        for (int i = 15; i >= 0; i--) begin
            spi_bit(1'b1, so);
            v[i] = so;
        end
        if (!keep_cs) cs_high();
    endtask

    task automatic t_reset();
        check("R9 cfg reset", cfg_word, CFG_DEF);
        check("R9 dcs reset", {15'd0, dcs_sel}, {15'd0, CFG_DEF[6]});
        check("R8 count reset", {11'd0, pay_count}, 16'd0);
        check("R5 miso idle", {15'd0, spi_miso}, 16'd0);
    endtask

    task automatic t_write_read();
        logic [15:0] v;
        wr_reg(8'hB1, 16'h1234);
        rd_reg(8'hB1, 1'b0, v);
        check("R2 R5 B1", v, 16'h1234);
        wr_reg(8'hCE, 16'hA55A);
        rd_reg(8'hCE, 1'b0, v);
        check("R1 R2 CE", v, 16'hA55A);
        check("R5 miso low after", {15'd0, spi_miso}, 16'd0);
    endtask

    task automatic t_cfg();
        wr_reg(8'hB7, 16'h0040);
        check("R9 cfg", cfg_word, 16'h0040);
        check("R9 dcs set", {15'd0, dcs_sel}, 16'd1);
        wr_reg(8'hB7, 16'h07BF);
        check("R9 cfg2", cfg_word, 16'h07BF);
        check("R9 dcs clr", {15'd0, dcs_sel}, 16'd0);
    endtask

    task automatic t_id();
        logic [15:0] v;
        rd_reg(8'hB0, 1'b0, v);
        check("R6 id", v, DEV_ID);
        wr_reg(8'hB0, 16'hFFFF);
        rd_reg(8'hB0, 1'b0, v);
        check("R6 id after write", v, DEV_ID);
    endtask

    task automatic t_unimpl();
        logic [15:0] v;
        wr_reg(8'h10, 16'h5555);
        rd_reg(8'h10, 1'b0, v);
        check("R7 low addr", v, 16'h0000);
        wr_reg(8'hEC, 16'h6666);
        rd_reg(8'hEC, 1'b0, v);
        check("R7 high addr", v, 16'h0000);
        wr_reg(8'hEB, 16'h7777);
        rd_reg(8'hEB, 1'b0, v);
        check("R7 last impl", v, 16'h7777);
    endtask

    task automatic t_partial();
        logic [15:0] v;
        logic so;
        cs_low();
        spi_word(1'b0, 8'hB2);
        spi_word(1'b1, 8'h11);
        cs_high();
        rd_reg(8'hB2, 1'b0, v);
        check("R3 no high byte", v, 16'h0000);
        cs_low();
        spi_word(1'b0, 8'hB3);
        spi_word(1'b1, 8'h44);
        spi_bit(1'b1, so);
        spi_bit(1'b0, so);
        spi_bit(1'b1, so);
        spi_bit(1'b1, so);
        cs_high();
        rd_reg(8'hB3, 1'b0, v);
        check("R3 partial word", v, 16'h0000);
        wr_reg(8'hB3, 16'h3322);
        rd_reg(8'hB3, 1'b0, v);
        check("R3 framing restored", v, 16'h3322);
    endtask

    task automatic t_packet();
        wr_reg(8'hBC, 16'd5);
        cs_low();
        spi_word(1'b0, 8'hBF);
        for (int i = 0; i < 7; i++) spi_word(1'b1, 8'h10 + 8'(i));
        cs_high();
        check("R4 len limit", {11'd0, pay_count}, 16'd5);
        for (int i = 0; i < 5; i++) begin
            pay_rd_idx = 4'(i);
            tick(1);
            check("R4 byte", {8'd0, pay_rd_byte}, {8'd0, 8'h10 + 8'(i)});
        end
        wr_reg(8'hBC, 16'd40);
        cs_low();
        spi_word(1'b0, 8'hBF);
        for (int i = 0; i < 20; i++) spi_word(1'b1, 8'h80 + 8'(i));
        cs_high();
        check("R4 depth limit", {11'd0, pay_count}, 16'd16);
        pay_rd_idx = 4'd15;
        tick(1);
        check("R4 last byte", {8'd0, pay_rd_byte}, 16'h008F);
        cs_low();
        spi_word(1'b0, 8'hBF);
        spi_word(1'b1, 8'hC1);
        spi_word(1'b1, 8'hC2);
        cs_high();
        check("R4 restart", {11'd0, pay_count}, 16'd2);
    endtask

    task automatic t_tx_ignore();
        logic [15:0] v;
        wr_reg(8'hB5, 16'hBEEF);
        rd_reg(8'hB5, 1'b1, v);
        check("R5 keep cs read", v, 16'hBEEF);
        spi_word(1'b0, 8'hB4);
        spi_word(1'b1, 8'h77);
        spi_word(1'b1, 8'h66);
        cs_high();
        rd_reg(8'hB4, 1'b0, v);
        check("R10 framing after read", v, 16'h6677);
    endtask

    task automatic t_srst();
        logic [15:0] v;
        wr_reg(8'hC0, 16'h0200);
        rd_reg(8'hC0, 1'b0, v);
        check("R8 other value stored", v, 16'h0200);
        wr_reg(8'hC0, 16'h0100);
        check("R8 cfg default", cfg_word, CFG_DEF);
        check("R8 count cleared", {11'd0, pay_count}, 16'd0);
        rd_reg(8'hB1, 1'b0, v);
        check("R8 B1 default", v, 16'h0000);
        rd_reg(8'hC0, 1'b0, v);
        check("R8 C0 default", v, 16'h0000);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_write_read();
        t_cfg();
        t_id();
        t_unimpl();
        t_partial();
        t_packet();
        t_tx_ignore();
        t_srst();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule